// File: doc/BRIEF.md
# Parallel DAC Bus Sequencer

This block sits on the host side of a 12-bit converter that has a parallel data bus. It turns single commands into correctly timed pin sequences on that bus. A command is a write into the converter's input register, a write followed by a load strobe, a load strobe on its own, or a readback of the input register. Commands arrive on a valid/ready handshake. The block drives active-low chip select, a direction line (high for read), an active-low load strobe, the write data and its output enable. It samples the returned bus word for readbacks.

Every timing minimum is a nanosecond parameter. Each one is turned into a whole number of system clock cycles when the design is elaborated. Write and read windows get separate, asymmetric budgets. A readback is followed by an enforced bus-release gap before the host may drive again. The load strobe is pulsed only while chip select is high and the bus word is stable. This matters because the converter's holding register is transparent while load is low.

Top module: `pdac_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, chip select, direction and load read 1 and bus enable reads 0. cmd_ready reads 1 and rsp_done reads 0.
- R2: cmd_op encodes 2'b00 write only, 2'b01 write then load, 2'b10 load only and 2'b11 readback. A command is taken in a cycle where cmd_valid and cmd_ready are both high. cmd_ready then stays low until the sequence ends. cmd_valid asserted while cmd_ready is low has no effect.
- R3: Each timing minimum becomes ceil(ns / CLK_PERIOD_NS) cycles, with a floor of one cycle. With the defaults (20 ns) these are: write select 3, read select 10, data setup 1, data hold 1, direction setup 1, data delay 8, bus release 5, load 3.
- R4: A write drives the word with bus_oe high and direction low for the data-setup count before chip select falls. It then holds chip select low for the write-select count. After chip select rises, it keeps direction low and the word driven, unchanged, for the data-hold count.
- R5: A readback raises direction and releases the bus for the direction-setup count before chip select falls.
- R6: A readback holds chip select low for max(read-select count, data-delay count) cycles. Direction stays high and bus_oe stays low throughout.
- R7: The readback word is taken from bus_in on the last cycle of the read window and is presented on rsp_data.
- R8: After a read window ends, chip select stays high and bus_oe stays low for the bus-release count before cmd_ready returns.
- R9: A load pulse holds dac_load_n low for the load count, and only while chip select is high. With 2'b01 it follows the write's hold cycles at once. With 2'b10 it starts in the cycle after acceptance.
- R10: rsp_done is a one-cycle pulse in the cycle cmd_ready returns, after every command. rsp_data changes only through a readback.
- R11: A command presented in the rsp_done cycle is accepted there, and its first phase appears in the next cycle.
- R12: A write-only command never drives dac_load_n low, so the converter's output register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command may be taken |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_data | input | DATA_W | Word for write commands |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Last readback word |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_rw | output | 1 | Direction: 1 read, 0 write |
| dac_load_n | output | 1 | Load strobe, active low |
| bus_out | output | DATA_W | Word driven toward the converter |
| bus_oe | output | 1 | Enable for the host bus driver |
| bus_in | input | DATA_W | Word returned by the converter |

## Verification
The completion of one command and the acceptance of the next can share a cycle. The bench provokes this by holding cmd_valid high across whole chains of commands, and by switching the command code right after each acceptance while the sequencer is still busy. The reference model expects the next command's first phase in the very cycle after rsp_done. It also expects that codes presented while busy change nothing. When a write follows a readback this way, the model checks that bus_oe stays low through the whole release gap. It also checks that the word read back comes from the converter model only once the data delay has elapsed.

// File: rtl/pdac_pkg.sv
`timescale 1ns/1ps
package pdac_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WSU   = 3'd1,
        PH_WCS   = 3'd2,
        PH_WHD   = 3'd3,
        PH_LOAD  = 3'd4,
        PH_RSU   = 3'd5,
        PH_RCS   = 3'd6,
        PH_RTURN = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        OP_WRITE      = 2'b00,
        OP_WRITE_LOAD = 2'b01,
        OP_LOAD       = 2'b10,
        OP_READ       = 2'b11
    } op_e;

    typedef struct packed {
        logic cs_n;
        logic rw;
        logic oe;
        logic load_n;
    } pins_t;

    // R3: ceiling division with a one-cycle floor
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // pin levels owned by each phase
    function automatic pins_t pins_of(input phase_e p);
        pins_t r;
        r = '{cs_n: 1'b1, rw: 1'b1, oe: 1'b0, load_n: 1'b1};
        case (p)
            PH_WSU:  r = '{cs_n: 1'b1, rw: 1'b0, oe: 1'b1, load_n: 1'b1};
            PH_WCS:  r = '{cs_n: 1'b0, rw: 1'b0, oe: 1'b1, load_n: 1'b1};
            PH_WHD:  r = '{cs_n: 1'b1, rw: 1'b0, oe: 1'b1, load_n: 1'b1};
            PH_LOAD: r = '{cs_n: 1'b1, rw: 1'b1, oe: 1'b0, load_n: 1'b0};
            PH_RCS:  r = '{cs_n: 1'b0, rw: 1'b1, oe: 1'b0, load_n: 1'b1};
            default: r = '{cs_n: 1'b1, rw: 1'b1, oe: 1'b0, load_n: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pdac_cnt.sv
`timescale 1ns/1ps
module pdac_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pdac_rdcap.sv
`timescale 1ns/1ps
module pdac_rdcap #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap_i) begin
            data_d = bus_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/pdac_fsm.sv
`timescale 1ns/1ps
module pdac_fsm
    import pdac_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CW     = 4,
    parameter int WSU_N  = 1,
    parameter int WCS_N  = 3,
    parameter int WHD_N  = 1,
    parameter int LD_N   = 3,
    parameter int RSU_N  = 1,
    parameter int RCS_N  = 10,
    parameter int TURN_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic              zero_i,
    output logic              cnt_ld_o,
    output logic [CW-1:0]     cnt_val_o,
    output logic              cap_o,
    output logic              ready_o,
    output logic              done_o,
    output logic              cs_n_o,
    output logic              rw_o,
    output logic              oe_o,
    output logic              load_n_o,
    output logic [DATA_W-1:0] bus_o
);

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic [DATA_W-1:0] bus;
        pins_t             pins;
        logic              done;
    } st_t;

    st_t    st_d, st_q;
    phase_e nxt;
    logic   move;

    // cycles remaining after the entry cycle of a phase
    function automatic logic [CW-1:0] span(input phase_e p);
        int n;
        case (p)
            PH_WSU:   n = WSU_N;
            PH_WCS:   n = WCS_N;
            PH_WHD:   n = WHD_N;
            PH_LOAD:  n = LD_N;
            PH_RSU:   n = RSU_N;
            PH_RCS:   n = RCS_N;
            PH_RTURN: n = TURN_N;
            default:  n = 1;
        endcase
        return CW'(n - 1);
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        nxt       = st_q.phase;
        move      = 1'b0;
        cap_o     = 1'b0;
        cnt_ld_o  = 1'b0;
        cnt_val_o = '0;

        case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid_i) begin
                    move    = 1'b1;
                    st_d.op = op_e'(cmd_op_i);
                    case (op_e'(cmd_op_i))
                        OP_LOAD: nxt = PH_LOAD;
                        OP_READ: nxt = PH_RSU;
                        default: begin
                            nxt      = PH_WSU;
                            st_d.bus = cmd_data_i;
                        end
                    endcase
                end
            end
            PH_WSU: begin
                if (zero_i) begin
                    move = 1'b1;
                    nxt  = PH_WCS;
                end
            end
            PH_WCS: begin
                if (zero_i) begin
                    move = 1'b1;
                    nxt  = PH_WHD;
                end
            end
            PH_WHD: begin
                if (zero_i) begin
                    move = 1'b1;
                    nxt  = (st_q.op == OP_WRITE_LOAD) ? PH_LOAD : PH_IDLE;
                end
            end
            PH_LOAD: begin
                if (zero_i) begin
                    move = 1'b1;
                    nxt  = PH_IDLE;
                end
            end
            PH_RSU: begin
                if (zero_i) begin
                    move = 1'b1;
                    nxt  = PH_RCS;
                end
            end
            PH_RCS: begin
                if (zero_i) begin
                    move  = 1'b1;
                    cap_o = 1'b1;
                    nxt   = PH_RTURN;
                end
            end
            PH_RTURN: begin
                if (zero_i) begin
                    move = 1'b1;
                    nxt  = PH_IDLE;
                end
            end
            default: begin
                move = 1'b1;
                nxt  = PH_IDLE;
            end
        endcase

        if (move) begin
            st_d.phase = nxt;
            if (nxt == PH_IDLE) begin
                st_d.done = 1'b1;
            end else begin
                cnt_ld_o  = 1'b1;
                cnt_val_o = span(nxt);
            end
        end

        st_d.pins = pins_of(st_d.phase);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.op    <= OP_WRITE;
            st_q.bus   <= '0;
            st_q.pins  <= '{cs_n: 1'b1, rw: 1'b1, oe: 1'b0, load_n: 1'b1};
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o  = (st_q.phase == PH_IDLE);
    assign done_o   = st_q.done;
    assign cs_n_o   = st_q.pins.cs_n;
    assign rw_o     = st_q.pins.rw;
    assign oe_o     = st_q.pins.oe;
    assign load_n_o = st_q.pins.load_n;
    assign bus_o    = st_q.bus;

endmodule

// File: rtl/pdac_seq.sv
`timescale 1ns/1ps
module pdac_seq
    import pdac_pkg::*;
#(
    parameter int DATA_W           = 12,
    parameter int CLK_PERIOD_NS    = 20,
    parameter int WR_CS_MIN_NS     = 50,
    parameter int RD_CS_MIN_NS     = 200,
    parameter int WR_DATA_SETUP_NS = 5,
    parameter int WR_DATA_HOLD_NS  = 5,
    parameter int RD_DIR_SETUP_NS  = 10,
    parameter int RD_DATA_DELAY_NS = 160,
    parameter int RD_RELEASE_NS    = 100,
    parameter int LOAD_MIN_NS      = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              dac_cs_n,
    output logic              dac_rw,
    output logic              dac_load_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_in
);

    // R3: phase lengths in clock cycles
    localparam int WSU_N  = ns_to_cycles(WR_DATA_SETUP_NS, CLK_PERIOD_NS);
    localparam int WCS_N  = ns_to_cycles(WR_CS_MIN_NS, CLK_PERIOD_NS);
    localparam int WHD_N  = ns_to_cycles(WR_DATA_HOLD_NS, CLK_PERIOD_NS);
    localparam int LD_N   = ns_to_cycles(LOAD_MIN_NS, CLK_PERIOD_NS);
    localparam int RSU_N  = ns_to_cycles(RD_DIR_SETUP_NS, CLK_PERIOD_NS);
    localparam int RCS_N  = max_int(ns_to_cycles(RD_CS_MIN_NS, CLK_PERIOD_NS),
                                    ns_to_cycles(RD_DATA_DELAY_NS, CLK_PERIOD_NS));
    localparam int TURN_N = ns_to_cycles(RD_RELEASE_NS, CLK_PERIOD_NS);
    localparam int MAXN   = max_int(max_int(max_int(WSU_N, WCS_N), max_int(WHD_N, LD_N)),
                                    max_int(max_int(RSU_N, RCS_N), TURN_N));
    localparam int CW     = $clog2(MAXN + 1);

    logic          zero;
    logic          cnt_ld;
    logic [CW-1:0] cnt_val;
    logic          cap;

    pdac_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (cnt_ld),
        .val_i  (cnt_val),
        .zero_o (zero)
    );

    pdac_fsm #(
        .DATA_W (DATA_W),
        .CW     (CW),
        .WSU_N  (WSU_N),
        .WCS_N  (WCS_N),
        .WHD_N  (WHD_N),
        .LD_N   (LD_N),
        .RSU_N  (RSU_N),
        .RCS_N  (RCS_N),
        .TURN_N (TURN_N)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_data_i  (cmd_data),
        .zero_i      (zero),
        .cnt_ld_o    (cnt_ld),
        .cnt_val_o   (cnt_val),
        .cap_o       (cap),
        .ready_o     (cmd_ready),
        .done_o      (rsp_done),
        .cs_n_o      (dac_cs_n),
        .rw_o        (dac_rw),
        .oe_o        (bus_oe),
        .load_n_o    (dac_load_n),
        .bus_o       (bus_out)
    );

    pdac_rdcap #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .bus_i  (bus_in),
        .data_o (rsp_data)
    );

endmodule

// File: rtl/pdac_seq_chk.sv
`timescale 1ns/1ps
module pdac_seq_chk
    import pdac_pkg::*;
#(
    parameter int DATA_W           = 12,
    parameter int CLK_PERIOD_NS    = 20,
    parameter int WR_CS_MIN_NS     = 50,
    parameter int RD_CS_MIN_NS     = 200,
    parameter int RD_DATA_DELAY_NS = 160,
    parameter int RD_RELEASE_NS    = 100,
    parameter int LOAD_MIN_NS      = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rsp_done,
    input logic              dac_cs_n,
    input logic              dac_rw,
    input logic              dac_load_n,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out
);

    localparam int WCS_N  = ns_to_cycles(WR_CS_MIN_NS, CLK_PERIOD_NS);
    localparam int RCS_N  = max_int(ns_to_cycles(RD_CS_MIN_NS, CLK_PERIOD_NS),
                                    ns_to_cycles(RD_DATA_DELAY_NS, CLK_PERIOD_NS));
    localparam int TURN_N = ns_to_cycles(RD_RELEASE_NS, CLK_PERIOD_NS);
    localparam int LD_N   = ns_to_cycles(LOAD_MIN_NS, CLK_PERIOD_NS);
    localparam int MAXN   = max_int(max_int(WCS_N, RCS_N), max_int(TURN_N, LD_N));
    localparam int CW     = $clog2(MAXN + 2) + 1;
    localparam logic [CW-1:0] SAT    = {CW{1'b1}};
    localparam logic [CW-1:0] WCS_L  = CW'(WCS_N);
    localparam logic [CW-1:0] RCS_L  = CW'(RCS_N);
    localparam logic [CW-1:0] TURN_L = CW'(TURN_N);
    localparam logic [CW-1:0] LD_L   = CW'(LD_N);

    logic [CW-1:0] cs_lo, ld_lo, gap;
    logic          rd_armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_lo    <= '0;
            ld_lo    <= '0;
            gap      <= '0;
            rd_armed <= 1'b0;
        end else begin
            cs_lo <= dac_cs_n ? '0 : ((cs_lo == SAT) ? cs_lo : cs_lo + 1'b1);
            ld_lo <= dac_load_n ? '0 : ((ld_lo == SAT) ? ld_lo : ld_lo + 1'b1);
            if (!dac_cs_n && dac_rw) begin
                rd_armed <= 1'b1;
                gap      <= '0;
            end else if (rd_armed && gap != SAT) begin
                gap <= gap + 1'b1;
            end
        end
    end

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_wr_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dac_cs_n) && !dac_rw) |-> ($past(!dac_rw) && $past(bus_oe)));

    p_cs_low_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && $past(!dac_cs_n)) |-> ($stable(dac_rw) && $stable(bus_oe) && $stable(bus_out)));

    p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_cs_n) && $past(!dac_rw)) |-> (!dac_rw && bus_oe && $stable(bus_out)));

    p_wr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_cs_n) && $past(!dac_rw)) |-> (cs_lo >= WCS_L));

    p_rd_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dac_cs_n) && dac_rw) |-> ($past(dac_rw) && $past(!bus_oe)));

    p_rd_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_rw) |-> !bus_oe);

    p_rd_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_cs_n) && $past(dac_rw)) |-> (cs_lo >= RCS_L));

    p_release_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!rd_armed || gap >= TURN_L));

    p_load_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load_n |-> dac_cs_n);

    p_load_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_load_n) |-> (ld_lo >= LD_L));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> cmd_ready);

endmodule

bind pdac_seq pdac_seq_chk #(
    .DATA_W           (DATA_W),
    .CLK_PERIOD_NS    (CLK_PERIOD_NS),
    .WR_CS_MIN_NS     (WR_CS_MIN_NS),
    .RD_CS_MIN_NS     (RD_CS_MIN_NS),
    .RD_DATA_DELAY_NS (RD_DATA_DELAY_NS),
    .RD_RELEASE_NS    (RD_RELEASE_NS),
    .LOAD_MIN_NS      (LOAD_MIN_NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .rsp_done   (rsp_done),
    .dac_cs_n   (dac_cs_n),
    .dac_rw     (dac_rw),
    .dac_load_n (dac_load_n),
    .bus_oe     (bus_oe),
    .bus_out    (bus_out)
);

// File: tb/tb_pdac_seq.sv
`timescale 1ns/1ps
module tb_pdac_seq;

    localparam int PERIOD = 20;

    // R3: expected cycle counts, from the nanosecond minimums
    function automatic int cyc(input int ns);
        int c;
        c = (ns + PERIOD - 1) / PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int WSU_C  = (5 + PERIOD - 1) / PERIOD;
    int WCS_C, WHD_C, LD_C, RSU_C, RCS_C, TURN_C, RVAL_C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_op;
    logic [11:0] cmd_data;
    logic        rsp_done;
    logic [11:0] rsp_data;
    logic        dac_cs_n, dac_rw, dac_load_n, bus_oe;
    logic [11:0] bus_out, bus_in;

    always #(PERIOD / 2) clk = ~clk;

    pdac_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .rsp_done   (rsp_done),
        .rsp_data   (rsp_data),
        .dac_cs_n   (dac_cs_n),
        .dac_rw     (dac_rw),
        .dac_load_n (dac_load_n),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .bus_in     (bus_in)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input bit ok, input int req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // converter model
    logic [11:0] in_reg = 12'h000;
    logic [11:0] out_reg = 12'h000;
    int          cs_lo = 0;
    logic        prev_cs_n = 1'b1, prev_rw = 1'b1;

    assign bus_in = (!dac_cs_n && dac_rw && cs_lo >= RVAL_C) ? in_reg : 12'h5A5;

    // expected per-cycle vector
    typedef struct packed {
        logic [5:0]  pins;    // cs_n rw oe load_n ready done
        logic [11:0] bus;
        logic [1:0]  rsp_mode; // 0 none, 1 hold, 2 new value
        logic [11:0] rsp;
        logic        chk_out;
        logic [11:0] outv;
        logic [7:0]  req;
        logic [7:0]  out_req;
    } exp_t;

    exp_t        q[$];
    logic [11:0] last_written = 12'h000;
    logic [11:0] exp_out = 12'h000;
    logic [11:0] rsp_hold = 12'h000;
    bit          run = 1'b0;

    task automatic push_n(input int n, input logic [3:0] p, input logic [11:0] b,
                          input int req, input bit first_b2b);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e = '0;
            e.pins = {p, 2'b00};
            e.bus = b;
            e.req = ((i == 0) && first_b2b) ? 8'd11 : 8'(req); // R11 on first cycle
            q.push_back(e);
        end
    endtask

    task automatic push_done(input bit is_read, input int oreq);
        exp_t e;
        e = '0;
        e.pins = 6'b110111;
        e.rsp_mode = is_read ? 2'd2 : 2'd1;
        e.rsp = last_written;
        e.chk_out = 1'b1;
        e.outv = exp_out;
        e.req = is_read ? 8'd7 : 8'd10;
        e.out_req = 8'(oreq);
        q.push_back(e);
    endtask

    // R2 codes: 00 write, 01 write+load, 10 load only, 11 readback
    task automatic push_cmd(input logic [1:0] op, input logic [11:0] d, input bit b2b);
        case (op)
            2'b00, 2'b01: begin
                last_written = d;
                push_n(WSU_C, 4'b1011, d, 4, b2b); // R4 setup
                push_n(WCS_C, 4'b0011, d, 4, 1'b0); // R4 select
                push_n(WHD_C, 4'b1011, d, 4, 1'b0); // R4 hold
                if (op == 2'b01) begin
                    exp_out = last_written;
                    push_n(LD_C, 4'b1100, d, 9, 1'b0); // R9
                    push_done(1'b0, 9);
                end else begin
                    push_done(1'b0, 12); // R12
                end
            end
            2'b10: begin
                exp_out = last_written;
                push_n(LD_C, 4'b1100, 12'h0, 9, b2b); // R9
                push_done(1'b0, 9);
            end
            default: begin
                push_n(RSU_C, 4'b1101, 12'h0, 5, b2b);  // R5
                push_n(RCS_C, 4'b0101, 12'h0, 6, 1'b0); // R6
                push_n(TURN_C, 4'b1101, 12'h0, 8, 1'b0); // R8
                push_done(1'b1, 12);
            end
        endcase
    endtask

    always @(negedge clk) begin : model
        exp_t e;
        logic [5:0] act;
        // converter model bookkeeping
        if (prev_cs_n == 1'b0 && dac_cs_n == 1'b1) begin
            // R3: observed select width against computed count
            chk(cs_lo == (prev_rw ? RCS_C : WCS_C), 3, "select width", cs_lo,
                prev_rw ? RCS_C : WCS_C);
            if (!prev_rw) in_reg = bus_oe ? bus_out : 12'hBAD;
        end
        if (!dac_cs_n) cs_lo++; else cs_lo = 0;
        if (!dac_load_n) out_reg = in_reg;
        prev_cs_n = dac_cs_n;
        prev_rw = dac_rw;

        if (run) begin
            if (q.size() > 0) begin
                e = q.pop_front();
            end else begin
                e = '0;
                e.pins = 6'b110110;
                e.rsp_mode = 2'd1;
                e.req = 8'd2;
            end
            act = {dac_cs_n, dac_rw, bus_oe, dac_load_n, cmd_ready, rsp_done};
            chk(act == e.pins, int'(e.req), "pins{cs,rw,oe,ld,rdy,done}", act, e.pins);
            if (e.pins[3]) chk(bus_out == e.bus, 4, "bus_out", bus_out, e.bus);
            if (e.rsp_mode == 2'd2) begin
                chk(rsp_data == e.rsp, 7, "readback", rsp_data, e.rsp);
                rsp_hold = e.rsp;
            end else if (e.rsp_mode == 2'd1) begin
                chk(rsp_data == rsp_hold, 10, "rsp_data hold", rsp_data, rsp_hold);
            end
            if (e.chk_out) chk(out_reg == e.outv, int'(e.out_req), "converter output reg",
                               out_reg, e.outv);
            if (e.pins[1] && cmd_valid) push_cmd(cmd_op, cmd_data, e.pins[0]);
        end
    end

    task automatic issue(input logic [1:0] op, input logic [11:0] d, input bit keep);
        @(posedge clk); #1;
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_data = d;
        do @(negedge clk); while (!cmd_ready);
        if (!keep) begin
            @(posedge clk); #1;
            cmd_valid = 1'b0;
        end
    endtask

    task automatic wait_idle(input int extra);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    initial begin
        WCS_C = cyc(50); WHD_C = cyc(5); LD_C = cyc(50); RSU_C = cyc(10);
        RVAL_C = cyc(160); TURN_C = cyc(100);
        RCS_C = (cyc(200) > RVAL_C) ? cyc(200) : RVAL_C;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_data = 12'h000;
        repeat (2) @(negedge clk);
        // R1: reset values
        chk({dac_cs_n, dac_rw, bus_oe, dac_load_n, cmd_ready, rsp_done} == 6'b110110, 1,
            "reset pins", {dac_cs_n, dac_rw, bus_oe, dac_load_n, cmd_ready, rsp_done}, 6'b110110);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk);

        issue(2'b00, 12'h123, 1'b0); wait_idle(3);  // R4 R12 write only
        issue(2'b10, 12'h000, 1'b0); wait_idle(2);  // R9 load only
        issue(2'b11, 12'h000, 1'b0); wait_idle(2);  // R5 R6 R7 R8 readback
        issue(2'b01, 12'hFFF, 1'b0); wait_idle(1);  // R9 write then load
        issue(2'b11, 12'h000, 1'b0); wait_idle(1);

        // R2: valid while busy must be ignored
        issue(2'b11, 12'h000, 1'b0);
        @(posedge clk); #1; cmd_valid = 1'b1; cmd_op = 2'b10; cmd_data = 12'h777;
        repeat (3) @(posedge clk);
        #1 cmd_valid = 1'b0;
        wait_idle(2);

        // R11: back-to-back chains, code switched while busy
        issue(2'b00, 12'h800, 1'b1);
        issue(2'b11, 12'h000, 1'b1);
        issue(2'b01, 12'h7FF, 1'b1);
        issue(2'b11, 12'h000, 1'b1);
        issue(2'b00, 12'h801, 1'b1);
        issue(2'b10, 12'h000, 1'b1);
        issue(2'b11, 12'h000, 1'b0);
        wait_idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule